// File: doc/BRIEF.md
# Regulator Control Register Target on a Two-Wire Serial Bus

This block is a two-wire serial bus target in front of a six-entry control file for a digitally set step-down regulator. The bus lines come in asynchronously and are sampled on the system clock. The block answers its own device address and decodes three transactions:
- a single-register write;
- a register read, done as a pointer write followed by a repeated START;
- a high-speed master code, which it lets pass without reacting.

The register file holds:
- two setpoint registers, each with a software enable and a 7-bit output code;
- a control register with output discharge, rising slew code, a self-clearing soft-reset bit and mode bits;
- two fixed identification registers;
- a monitor register. Its bits come from regulator status inputs, except for one flag that records a soft reset and clears once the register has been read.

The register contents drive the regulator through plain output ports. The SDA output is a pull-down request for an open-drain pad.

Top module: `buck_ctl_i2c_target`

## Requirements
- R1: An address byte whose upper seven bits equal the upper seven bits of the DEV_ADDR parameter (default 8'hA4) is acknowledged by pulling SDA low in the ninth clock. Any other address byte is not acknowledged, and the target stays silent until the next START or STOP.
- R2: START, address with bit 0 = 0, register index, data byte, STOP writes the data into the indexed register. Indices 0 and 1 are the setpoints and index 2 is control. The new contents appear on set0_o, set1_o or ctrl_o.
- R3: START, address+write, index, repeated START, address with bit 0 = 1 makes the target shift out the indexed register MSB first, with bits changing only while SCL is low. A master ACK (SDA low) after the byte makes the target send the same register again. A master NACK ends the read.
- R4: After reset the registers hold the following values: index 0 = {1'b1, CODE0}, index 1 = {1'b1, CODE1}, index 2 = 8'h82, index 3 = 8'h81 and index 4 = 8'h08.
- R5: Bits 3 and 2 of the control register always read 0.
- R6: Writing control with bit 2 set puts every writable register back to its reset value, and that data is not stored.
- R7: Index 5 reads {stat_i[6:2], rst_flag, stat_i[1:0]}. rst_flag is set by a soft reset and cleared once a byte of index 5 has been sent.
- R8: Writes to index 3, 4, 5 or any index above 5 are acknowledged and change nothing. A read of any index above 5 returns 8'h00.
- R9: An address byte of the form 8'b00001xxx is never acknowledged. A repeated START that follows it begins an ordinary transaction.
- R10: A START or STOP in the middle of a byte abandons the transfer, and no partial byte is written.
- R11: The SDA pull-down changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, well above the SCL rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the pad, asynchronous |
| stat_i | input | 7 | Regulator status flags for the monitor register |
| sda_pd_o | output | 1 | Request to pull SDA low |
| set0_o | output | 8 | Setpoint register 0 (enable, code) |
| set1_o | output | 8 | Setpoint register 1 (enable, code) |
| ctrl_o | output | 8 | Control register |

## Verification
The bench offers all 128 seven-bit addresses. A target that decodes too many or too few address bits would acknowledge a foreign device or ignore its own address. It then sends each of the eight high-speed codes ahead of a real write, to catch a target that acknowledges the code or loses track at the repeated START. Writes to the read-only and unmapped indices, a soft reset followed by two reads of the monitor register, and a STOP or START placed mid-byte together expose three kinds of fault: stray stores, a reset flag that never clears or clears too early, and partial bytes that get committed.

// File: rtl/buck_ctl_i2c_pkg.sv
package buck_ctl_i2c_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned NUM_REGS = 6;
  localparam logic [7:0] IDX_SET0 = 8'h00;
  localparam logic [7:0] IDX_SET1 = 8'h01;
  localparam logic [7:0] IDX_CTRL = 8'h02;
  localparam logic [7:0] IDX_ID_A = 8'h03;
  localparam logic [7:0] IDX_ID_B = 8'h04;
  localparam logic [7:0] IDX_MON  = 8'h05;
  localparam logic [7:0] ID_A_VAL = 8'h81;
  localparam logic [7:0] ID_B_VAL = 8'h08;
  localparam logic [7:0] CTRL_DEF = 8'h82;
  localparam int unsigned CTRL_SRST_BIT = 2;
  localparam logic [4:0] HS_CODE_TOP = 5'b00001;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_INDEX, ST_WDATA, ST_ACK, ST_RDATA, ST_MACK, ST_SKIP
  } link_st_e;
endpackage

// File: rtl/buck_ctl_i2c_sync.sv
module buck_ctl_i2c_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic rise_o,
  output logic fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_q  <= scl_sh[STAGES-1];
      sda_q  <= sda_sh[STAGES-1];
    end
  end

  assign scl_o   = scl_sh[STAGES-1];
  assign sda_o   = sda_sh[STAGES-1];
  assign rise_o  = scl_o & ~scl_q;
  assign fall_o  = ~scl_o & scl_q;
  // SDA edge while SCL holds high
  assign start_o = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o  = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/buck_ctl_i2c_link.sv
module buck_ctl_i2c_link
  import buck_ctl_i2c_pkg::*;
#(
  parameter logic [7:0] DEV_ADDR = 8'hA4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sda_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic             wr_en_o,
  output logic [BYTE_W-1:0] idx_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic             rd_take_o,
  output logic             sda_pd_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  link_st_e st, nxt;
  logic [CNT_W-1:0] cnt;
  logic [BYTE_W-1:0] sh, tx, idx;
  logic mack;
  logic addr_hit, hs_code;

  assign addr_hit = (sh[7:1] == DEV_ADDR[7:1]);
  assign hs_code  = (sh[7:3] == HS_CODE_TOP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st        <= ST_IDLE;
      nxt       <= ST_IDLE;
      cnt       <= '0;
      sh        <= '0;
      tx        <= '0;
      idx       <= '0;
      mack      <= 1'b1;
      wr_en_o   <= 1'b0;
      rd_take_o <= 1'b0;
    end else begin
      wr_en_o   <= 1'b0;
      rd_take_o <= 1'b0;
      if (stop_i) begin
        st <= ST_IDLE;
      end else if (start_i) begin
        st  <= ST_ADDR;
        cnt <= '0;
      end else begin
        unique case (st)
          ST_ADDR, ST_INDEX, ST_WDATA: begin
            if (rise_i && cnt < FULL) begin
              sh  <= {sh[BYTE_W-2:0], sda_i};
              cnt <= cnt + 1'b1;
            end else if (fall_i && cnt == FULL) begin
              if (st == ST_ADDR) begin
                if (addr_hit && !hs_code) begin
                  st  <= ST_ACK;
                  nxt <= sh[0] ? ST_RDATA : ST_INDEX;
                end else begin
                  st <= ST_SKIP;
                end
              end else if (st == ST_INDEX) begin
                idx <= sh;
                st  <= ST_ACK;
                nxt <= ST_WDATA;
              end else begin
                wr_en_o <= 1'b1;
                st      <= ST_ACK;
                nxt     <= ST_SKIP;
              end
            end
          end
          ST_ACK: begin
            if (fall_i) begin
              st  <= nxt;
              cnt <= '0;
              if (nxt == ST_RDATA) begin
                tx        <= rd_data_i;
                rd_take_o <= 1'b1;
              end
            end
          end
          ST_RDATA: begin
            if (fall_i) begin
              if (cnt == LAST) begin
                st <= ST_MACK;
              end else begin
                tx  <= {tx[BYTE_W-2:0], 1'b0};
                cnt <= cnt + 1'b1;
              end
            end
          end
          ST_MACK: begin
            if (rise_i) mack <= sda_i;
            else if (fall_i) begin
              if (!mack) begin
                st        <= ST_RDATA;
                cnt       <= '0;
                tx        <= rd_data_i;
                rd_take_o <= 1'b1;
              end else begin
                st <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign idx_o     = idx;
  assign wr_data_o = sh;
  assign sda_pd_o  = (st == ST_ACK) || (st == ST_RDATA && !tx[BYTE_W-1]);
endmodule

// File: rtl/buck_ctl_i2c_regs.sv
module buck_ctl_i2c_regs
  import buck_ctl_i2c_pkg::*;
#(
  parameter logic [6:0] CODE0 = 7'd40,
  parameter logic [6:0] CODE1 = 7'd88
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [BYTE_W-1:0] idx_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic             rd_take_i,
  input  logic [6:0]       stat_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic [BYTE_W-1:0] set0_o,
  output logic [BYTE_W-1:0] set1_o,
  output logic [BYTE_W-1:0] ctrl_o
);
  localparam logic [7:0] SET0_DEF = {1'b1, CODE0};
  localparam logic [7:0] SET1_DEF = {1'b1, CODE1};

  logic [7:0] set0, set1, ctrl;
  logic rst_flag;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      set0     <= SET0_DEF;
      set1     <= SET1_DEF;
      ctrl     <= CTRL_DEF;
      rst_flag <= 1'b0;
    end else if (wr_en_i) begin
      unique case (idx_i)
        IDX_SET0: set0 <= wr_data_i;
        IDX_SET1: set1 <= wr_data_i;
        IDX_CTRL: begin
          if (wr_data_i[CTRL_SRST_BIT]) begin
            set0     <= SET0_DEF;
            set1     <= SET1_DEF;
            ctrl     <= CTRL_DEF;
            rst_flag <= 1'b1;
          end else begin
            ctrl <= {wr_data_i[7:4], 2'b00, wr_data_i[1:0]};
          end
        end
        default: ;
      endcase
    end else if (rd_take_i && idx_i == IDX_MON) begin
      rst_flag <= 1'b0;
    end
  end

  always_comb begin
    unique case (idx_i)
      IDX_SET0: rd_data_o = set0;
      IDX_SET1: rd_data_o = set1;
      IDX_CTRL: rd_data_o = ctrl;
      IDX_ID_A: rd_data_o = ID_A_VAL;
      IDX_ID_B: rd_data_o = ID_B_VAL;
      IDX_MON:  rd_data_o = {stat_i[6:2], rst_flag, stat_i[1:0]};
      default:  rd_data_o = '0;
    endcase
  end

  assign set0_o = set0;
  assign set1_o = set1;
  assign ctrl_o = ctrl;
endmodule

// File: rtl/buck_ctl_i2c_target.sv
module buck_ctl_i2c_target
  import buck_ctl_i2c_pkg::*;
#(
  parameter logic [7:0] DEV_ADDR = 8'hA4,
  parameter logic [6:0] CODE0    = 7'd40,
  parameter logic [6:0] CODE1    = 7'd88,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [6:0] stat_i,
  output logic       sda_pd_o,
  output logic [7:0] set0_o,
  output logic [7:0] set1_o,
  output logic [7:0] ctrl_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_d, stop_d;
  logic wr_en, rd_take;
  logic [BYTE_W-1:0] reg_idx, wr_data, rd_data;

  buck_ctl_i2c_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .scl_i   (scl_i),
    .sda_i   (sda_i),
    .scl_o   (scl_s),
    .sda_o   (sda_s),
    .rise_o  (scl_rise),
    .fall_o  (scl_fall),
    .start_o (start_d),
    .stop_o  (stop_d)
  );

  buck_ctl_i2c_link #(.DEV_ADDR(DEV_ADDR)) i_link (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sda_i     (sda_s),
    .rise_i    (scl_rise),
    .fall_i    (scl_fall),
    .start_i   (start_d),
    .stop_i    (stop_d),
    .rd_data_i (rd_data),
    .wr_en_o   (wr_en),
    .idx_o     (reg_idx),
    .wr_data_o (wr_data),
    .rd_take_o (rd_take),
    .sda_pd_o  (sda_pd_o)
  );

  buck_ctl_i2c_regs #(.CODE0(CODE0), .CODE1(CODE1)) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .idx_i     (reg_idx),
    .wr_data_i (wr_data),
    .rd_take_i (rd_take),
    .stat_i    (stat_i),
    .rd_data_o (rd_data),
    .set0_o    (set0_o),
    .set1_o    (set1_o),
    .ctrl_o    (ctrl_o)
  );
endmodule

// File: rtl/buck_ctl_i2c_chk.sv
module buck_ctl_i2c_chk #(
  parameter logic [6:0] CODE0 = 7'd40,
  parameter logic [6:0] CODE1 = 7'd88
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       scl_s,
  input logic       stop_d,
  input logic       wr_en,
  input logic [7:0] reg_idx,
  input logic [7:0] wr_data,
  input logic       sda_pd_o,
  input logic [7:0] set0_o,
  input logic [7:0] set1_o,
  input logic [7:0] ctrl_o
);
  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_pd_o) |-> !scl_s); // R11

  AST_CTRL_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[3:2] == 2'b00); // R5

  AST_SOFT_RESET_DEFAULTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && reg_idx == 8'h02 && wr_data[2]) |=>
      (ctrl_o == 8'h82 && set0_o == {1'b1, CODE0} && set1_o == {1'b1, CODE1})); // R6

  AST_RO_WRITE_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && reg_idx > 8'h02) |=> $stable({set0_o, set1_o, ctrl_o})); // R8

  AST_SET0_TAKES_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && reg_idx == 8'h00) |=> set0_o == $past(wr_data)); // R2

  AST_STOP_RELEASES_SDA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_d |=> !sda_pd_o); // R10
endmodule

bind buck_ctl_i2c_target buck_ctl_i2c_chk #(.CODE0(CODE0), .CODE1(CODE1)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .scl_s    (scl_s),
  .stop_d   (stop_d),
  .wr_en    (wr_en),
  .reg_idx  (reg_idx),
  .wr_data  (wr_data),
  .sda_pd_o (sda_pd_o),
  .set0_o   (set0_o),
  .set1_o   (set1_o),
  .ctrl_o   (ctrl_o)
);

// File: tb/test_buck_ctl_i2c_target.sv
module test_buck_ctl_i2c_target;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;
  localparam logic [6:0] MY_ADDR = 7'h52;
  localparam logic [7:0] SET0_DEF = 8'hA8;
  localparam logic [7:0] SET1_DEF = 8'hD8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic [6:0] stat = 7'h55;
  logic sda_pd;
  logic [7:0] set0, set1, ctrl;
  logic sda_bus;
  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  assign sda_bus = sda_m & ~sda_pd;
  always #(CLK_PERIOD / 2) clk = ~clk;

  buck_ctl_i2c_target i_buck_ctl_i2c_target (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .stat_i(stat),
    .sda_pd_o(sda_pd), .set0_o(set0), .set1_o(set1), .ctrl_o(ctrl)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hp(input int n = HALF);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hp(); scl_m = 1'b1; hp(); sda_m = 1'b0; hp(); scl_m = 1'b0; hp();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hp(); scl_m = 1'b1; hp(); sda_m = 1'b1; hp();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; hp(); scl_m = 1'b1; hp(); scl_m = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    sda_m = 1'b1; hp(); scl_m = 1'b1; hp(HALF / 2);
    ack = (sda_bus == 1'b0);
    hp(HALF / 2); scl_m = 1'b0;
  endtask

  task automatic recv_byte(input bit nack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      hp(); scl_m = 1'b1; hp(HALF / 2); b = {b[6:0], sda_bus}; hp(HALF / 2); scl_m = 1'b0;
    end
    sda_m = nack; hp(); scl_m = 1'b1; hp(); scl_m = 1'b0;
  endtask

  task automatic write_reg(input logic [7:0] idx, input logic [7:0] d, output bit acks);
    bit a0, a1, a2;
    bus_start();
    send_byte({MY_ADDR, 1'b0}, a0);
    send_byte(idx, a1);
    send_byte(d, a2);
    bus_stop();
    acks = a0 & a1 & a2;
  endtask

  task automatic read_reg(input logic [7:0] idx, output logic [7:0] d, output bit acks);
    bit a0, a1, a2;
    bus_start();
    send_byte({MY_ADDR, 1'b0}, a0);
    send_byte(idx, a1);
    bus_start();
    send_byte({MY_ADDR, 1'b1}, a2);
    recv_byte(1'b1, d);
    bus_stop();
    acks = a0 & a1 & a2;
  endtask

  function automatic logic [7:0] mon_exp(input logic [6:0] s, input bit f);
    return {s[6:2], f, s[1:0]};
  endfunction

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, d2, v, exp_r[8];
    bit ok;
    hp(4);
    // R4 reset state at the ports
    chk(set0 == SET0_DEF, "R4 set0 reset", set0, SET0_DEF);
    chk(set1 == SET1_DEF, "R4 set1 reset", set1, SET1_DEF);
    chk(ctrl == 8'h82, "R4 ctrl reset", ctrl, 8'h82);
    chk(sda_pd == 1'b0, "R4 sda idle in reset", sda_pd, 0);
    rst_n = 1'b1;
    hp(4);

    // R4 R7 R8 read sweep of every index 0..7
    exp_r = '{SET0_DEF, SET1_DEF, 8'h82, 8'h81, 8'h08, mon_exp(stat, 1'b0), 8'h00, 8'h00};
    for (int a = 0; a < 8; a++) begin
      read_reg(8'(a), d, ok);
      chk(ok, "R3 read acks", ok, 1);
      chk(d == exp_r[a], "R4 R7 R8 read reset value", d, exp_r[a]);
    end

    // R1 address sweep across all seven-bit addresses
    for (int a = 0; a < 128; a++) begin
      bus_start();
      send_byte({7'(a), 1'b0}, ok);
      bus_stop();
      chk(ok == (7'(a) == MY_ADDR), "R1 address ack", ok, (7'(a) == MY_ADDR));
    end

    // R9 high-speed master code, then repeated START with a real write
    for (int k = 0; k < 8; k++) begin
      bit a0, a1, a2, a3;
      bus_start();
      send_byte({5'b00001, 3'(k)}, a0);
      chk(!a0, "R9 master code not acked", a0, 0);
      bus_start();
      send_byte({MY_ADDR, 1'b0}, a1);
      send_byte(8'h00, a2);
      send_byte(8'(k * 3 + 1), a3);
      bus_stop();
      chk(a1 & a2 & a3, "R9 transaction after code", {a1, a2, a3}, 3'b111);
      chk(set0 == 8'(k * 3 + 1), "R9 write after code", set0, k * 3 + 1);
    end

    // R2 R3 write/read sweep on setpoints
    for (int r = 0; r < 2; r++) begin
      for (int i = 0; i < 8; i++) begin
        v = 8'(i * 37 + 5);
        write_reg(8'(r), v, ok);
        chk(ok, "R2 write acks", ok, 1);
        chk((r == 0 ? set0 : set1) == v, "R2 setpoint port", (r == 0 ? set0 : set1), v);
        read_reg(8'(r), d, ok);
        chk(d == v, "R3 setpoint readback", d, v);
      end
    end

    // R5 control register: bits 3 and 2 read 0
    for (int i = 0; i < 8; i++) begin
      v = 8'(i * 37 + 5) & 8'hFB;
      write_reg(8'h02, v, ok);
      chk(ctrl == (v & 8'hF3), "R5 ctrl port", ctrl, v & 8'hF3);
      read_reg(8'h02, d, ok);
      chk(d == (v & 8'hF3), "R5 ctrl readback", d, v & 8'hF3);
    end

    // R3 master ACK continues with the same register
    bus_start();
    send_byte({MY_ADDR, 1'b0}, ok);
    send_byte(8'h03, ok);
    bus_start();
    send_byte({MY_ADDR, 1'b1}, ok);
    recv_byte(1'b0, d);
    recv_byte(1'b1, d2);
    bus_stop();
    chk(d == 8'h81 && d2 == 8'h81, "R3 repeated byte on master ack", {d, d2}, 16'h8181);

    // R8 writes to read-only and unmapped indices
    write_reg(8'h00, 8'h11, ok);
    write_reg(8'h01, 8'h22, ok);
    write_reg(8'h02, 8'h31, ok);
    foreach (exp_r[j]) begin
      logic [7:0] tgt;
      tgt = (j < 3) ? 8'(j + 3) : (j < 6 ? 8'(j * 40) : 8'hFF);
      write_reg(tgt, 8'h5A, ok);
      chk(ok, "R8 write to ro/unmapped acked", ok, 1);
    end
    chk({set0, set1, ctrl} == 24'h112231, "R8 no effect on ports", {set0, set1, ctrl}, 24'h112231);
    read_reg(8'h03, d, ok); chk(d == 8'h81, "R8 id A unchanged", d, 8'h81);
    read_reg(8'h04, d, ok); chk(d == 8'h08, "R8 id B unchanged", d, 8'h08);
    read_reg(8'h05, d, ok); chk(d == mon_exp(stat, 1'b0), "R8 monitor unchanged", d, mon_exp(stat, 1'b0));

    // R10 STOP mid-byte
    bus_start();
    send_byte({MY_ADDR, 1'b0}, ok);
    send_byte(8'h00, ok);
    send_bits(8'hF0, 4);
    bus_stop();
    chk(set0 == 8'h11, "R10 stop mid-byte", set0, 8'h11);
    // R10 START mid-byte, then full write to index 1
    bus_start();
    send_byte({MY_ADDR, 1'b0}, ok);
    send_byte(8'h00, ok);
    send_bits(8'h0F, 3);
    write_reg(8'h01, 8'h44, ok);
    chk(set0 == 8'h11 && set1 == 8'h44, "R10 start mid-byte", {set0, set1}, 16'h1144);

    // R6 R7 soft reset and clear-on-read flag
    stat = 7'h2A;
    write_reg(8'h02, 8'h04, ok);
    chk({set0, set1, ctrl} == {SET0_DEF, SET1_DEF, 8'h82}, "R6 soft reset defaults",
        {set0, set1, ctrl}, {SET0_DEF, SET1_DEF, 8'h82});
    read_reg(8'h02, d, ok);
    chk(d == 8'h82, "R6 reset bit reads 0", d, 8'h82);
    read_reg(8'h05, d, ok);
    chk(d == mon_exp(stat, 1'b1), "R7 flag set after soft reset", d, mon_exp(stat, 1'b1));
    read_reg(8'h05, d, ok);
    chk(d == mon_exp(stat, 1'b0), "R7 flag cleared by read", d, mon_exp(stat, 1'b0));
    stat = 7'h7F;
    read_reg(8'h05, d, ok);
    chk(d == mon_exp(stat, 1'b0), "R7 status follows inputs", d, mon_exp(stat, 1'b0));
    chk(sda_pd == 1'b0, "R11 bus released when idle", sda_pd, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule